// File: doc/BRIEF.md
# Power-down clock and pin controller

This block decides when a small programmable peripheral drops into a low-power state, and what it does to its clocks and pins while it is there. A bus-writable control register carries one gate bit for each of three clock domains: the logic array clock, the macrocell register clock and the timer clock. The same register enables an idle counter and selects whether an idle timeout enters power-down or sleep. A second write target holds the idle counter's terminal count.

The idle counter advances on every clock cycle with no bus activity. It clears on any bus access, on any register write and on the wake input. When it reaches the terminal count, the state machine leaves `ST_RUN` and sets the overflow flag. Transition `T_IDLE_PD` leads to `ST_PDOWN`, and `T_IDLE_SLEEP` leads to `ST_SLEEP`. While in either low-power state the counter is frozen. Transition `T_WAKE` returns to `ST_RUN` and clears the flag. It fires on bus activity, on a register write or on the wake input. The enable of the clock input buffer drops only when all three gate bits are set and the flag is up.

In low power, each pin class is handled separately. General I/O holds the value and enable it had on the entry edge. The data port and the peripheral port lose their output enables. The address output is driven to zero. The logic outputs keep following their inputs in every state.

Top module: `pwrdn_ctrl`

## Requirements
- R1: After reset, all control fields and the terminal count are zero and the state is `ST_RUN`. `pd_o`, `sleep_o` and `ovf_o` are 0, `clkin_buf_en_o` is 1 and all three gated clocks toggle with `clk`.
- R2: Control register (written with `wr_sel_i`=0) bit 5 set stops `arr_clk_o`. The macrocell and timer clocks keep running.
- R3: Control register bit 6 set stops `mc_clk_o`. The other two clocks keep running.
- R4: Control register bit 7 set stops `tmr_clk_o`. The other two clocks keep running.
- R5: With control bit 0 set and terminal count TC (written with `wr_sel_i`=1), the state changes on the (TC+1)-th consecutive idle clock edge after the last activity, and `ovf_o` goes to 1 on that same edge. The target is `ST_PDOWN` (`pd_o`=1) when control bit 1 is 0 and `ST_SLEEP` (`sleep_o`=1) when it is 1. With bit 0 clear the state never leaves `ST_RUN`.
- R6: A cycle with `bus_act_i`, `wr_en_i` or `wake_i` high clears the idle count, so the timeout restarts from that edge.
- R7: The idle count is frozen in low power and cleared on exit. After a wake, reaching low power again takes a full TC+1 idle cycles.
- R8: In `ST_PDOWN` or `ST_SLEEP`, a cycle with `wake_i` or `bus_act_i` high returns the state to `ST_RUN` on that edge. On the same edge `ovf_o` clears and `clkin_buf_en_o` returns to 1.
- R9: `clkin_buf_en_o` is 0 only when control bits 5, 6 and 7 are all set and `ovf_o` is 1. If any one of those bits is clear, the enable stays at 1 in low power.
- R10: In low power, `io_o` and `io_oe_o` hold the values `io_i` and `io_oe_i` had on the entry edge. In `ST_RUN` they pass `io_i` and `io_oe_i` through.
- R11: In low power, `data_oe_o` and `per_oe_o` are 0 and `addr_o` is 0. In `ST_RUN`, the enables and the address pass through unchanged.
- R12: `logic_o` equals `logic_i` in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock input |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe (also counts as bus activity) |
| wr_sel_i | input | 1 | 0: control register, 1: terminal count |
| wr_data_i | input | REGW | Write data |
| bus_act_i | input | 1 | Bus access or chip-select activity |
| wake_i | input | 1 | Wake request |
| logic_i | input | LW | Logic array outputs |
| logic_o | output | LW | Logic outputs to pins |
| io_i | input | IOW | General I/O output values |
| io_oe_i | input | IOW | General I/O output enables |
| io_o | output | IOW | General I/O pin values |
| io_oe_o | output | IOW | General I/O pin enables |
| data_i | input | DW | Data port values |
| data_oe_i | input | 1 | Data port enable |
| data_o | output | DW | Data port pin values |
| data_oe_o | output | 1 | Data port pin enable |
| addr_i | input | AW | Address output values |
| addr_o | output | AW | Address pins |
| per_i | input | PW | Peripheral port values |
| per_oe_i | input | 1 | Peripheral port enable |
| per_o | output | PW | Peripheral pin values |
| per_oe_o | output | 1 | Peripheral pin enable |
| arr_clk_o | output | 1 | Gated logic array clock |
| mc_clk_o | output | 1 | Gated macrocell register clock |
| tmr_clk_o | output | 1 | Gated timer clock |
| clkin_buf_en_o | output | 1 | Clock input buffer enable |
| pd_o | output | 1 | State is power-down |
| sleep_o | output | 1 | State is sleep |
| ovf_o | output | 1 | Idle counter overflow flag |

## Verification
State changes land on the clock edge that sees the terminal count or the wake. Counting from the edge that captured the last write or activity, entry is due on edge TC+1 and exit on the edge that sees the wake. The bench drives inputs at falling edges and reads outputs at the next falling edge. It checks "not yet" after TC edges and "entered" after one more. Pin and buffer results follow the state register directly, so they are read in that same half cycle. Gated clocks are judged by counting their rising edges over an eight-cycle window. The window opens one falling edge after a write, which gives the enable latch time to take the new value.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_PDOWN = 2'd1,
        ST_SLEEP = 2'd2
    } pd_state_e;

    localparam int unsigned BIT_CNT_EN  = 0;
    localparam int unsigned BIT_SLP_SEL = 1;
    localparam int unsigned BIT_ARR_OFF = 5;
    localparam int unsigned BIT_MC_OFF  = 6;
    localparam int unsigned BIT_TMR_OFF = 7;
    localparam int unsigned NUM_GATES   = 3;
endpackage

// File: rtl/pd_clk_gate.sv
module pd_clk_gate (
    input  logic clk,
    input  logic en_i,
    output logic gclk_o
);
    logic en_l;

    // enable is sampled only while clk is low, so gclk_o cannot glitch
    always_latch begin
        if (!clk) en_l = en_i;
    end

    assign gclk_o = clk & en_l;
endmodule

// File: rtl/pd_idle_cnt.sv
module pd_idle_cnt #(
    parameter int unsigned TCW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_i,
    input  logic           clr_i,
    input  logic           lp_i,
    input  logic [TCW-1:0] tc_i,
    output logic           hit_o
);
    logic [TCW-1:0] cnt_q;

    assign hit_o = en_i && !clr_i && !lp_i && (cnt_q == tc_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (en_i && !lp_i && !hit_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_i && !clr_i) |=> $stable(cnt_q)); // R7
    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/pd_fsm.sv
module pd_fsm
    import pwrdn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic wake_i,
    input  logic sleep_sel_i,
    output logic lp_o,
    output logic pd_o,
    output logic sleep_o,
    output logic ovf_o
);
    pd_state_e state_q, state_d;
    logic      ovf_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (hit_i) state_d = sleep_sel_i ? ST_SLEEP : ST_PDOWN; // T_IDLE_SLEEP / T_IDLE_PD
            end
            ST_PDOWN, ST_SLEEP: begin
                if (wake_i) state_d = ST_RUN; // T_WAKE
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            ovf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (hit_i) ovf_q <= 1'b1;
            else if (wake_i && state_q != ST_RUN) ovf_q <= 1'b0;
        end
    end

    always_comb begin
        lp_o    = 1'b0;
        pd_o    = 1'b0;
        sleep_o = 1'b0;
        unique case (state_q)
            ST_RUN:   ;
            ST_PDOWN: begin lp_o = 1'b1; pd_o = 1'b1; end
            ST_SLEEP: begin lp_o = 1'b1; sleep_o = 1'b1; end
            default:  ;
        endcase
        ovf_o = ovf_q;
    end

    AST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |=> (ovf_o && lp_o)); // R5
    AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_o && wake_i) |=> (!lp_o && !ovf_o)); // R8
endmodule

// File: rtl/pd_pin_ctrl.sv
module pd_pin_ctrl #(
    parameter int unsigned IOW = 8,
    parameter int unsigned DW  = 8,
    parameter int unsigned AW  = 16,
    parameter int unsigned PW  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           lp_i,
    input  logic [IOW-1:0] io_i,
    input  logic [IOW-1:0] io_oe_i,
    output logic [IOW-1:0] io_o,
    output logic [IOW-1:0] io_oe_o,
    input  logic [DW-1:0]  data_i,
    input  logic           data_oe_i,
    output logic [DW-1:0]  data_o,
    output logic           data_oe_o,
    input  logic [AW-1:0]  addr_i,
    output logic [AW-1:0]  addr_o,
    input  logic [PW-1:0]  per_i,
    input  logic           per_oe_i,
    output logic [PW-1:0]  per_o,
    output logic           per_oe_o
);
    logic [IOW-1:0] io_hold_q, io_oe_hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            io_hold_q    <= '0;
            io_oe_hold_q <= '0;
        end else if (!lp_i) begin
            io_hold_q    <= io_i;
            io_oe_hold_q <= io_oe_i;
        end
    end

    always_comb begin
        io_o      = lp_i ? io_hold_q    : io_i;
        io_oe_o   = lp_i ? io_oe_hold_q : io_oe_i;
        data_o    = data_i;
        data_oe_o = data_oe_i && !lp_i;
        per_o     = per_i;
        per_oe_o  = per_oe_i && !lp_i;
        addr_o    = lp_i ? '0 : addr_i;
    end

    AST_IO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_i && $past(lp_i)) |-> ($stable(io_o) && $stable(io_oe_o))); // R10
endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
    import pwrdn_pkg::*;
#(
    parameter int unsigned REGW = 8,
    parameter int unsigned LW   = 4,
    parameter int unsigned IOW  = 8,
    parameter int unsigned DW   = 8,
    parameter int unsigned AW   = 16,
    parameter int unsigned PW   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en_i,
    input  logic            wr_sel_i,
    input  logic [REGW-1:0] wr_data_i,
    input  logic            bus_act_i,
    input  logic            wake_i,
    input  logic [LW-1:0]   logic_i,
    output logic [LW-1:0]   logic_o,
    input  logic [IOW-1:0]  io_i,
    input  logic [IOW-1:0]  io_oe_i,
    output logic [IOW-1:0]  io_o,
    output logic [IOW-1:0]  io_oe_o,
    input  logic [DW-1:0]   data_i,
    input  logic            data_oe_i,
    output logic [DW-1:0]   data_o,
    output logic            data_oe_o,
    input  logic [AW-1:0]   addr_i,
    output logic [AW-1:0]   addr_o,
    input  logic [PW-1:0]   per_i,
    input  logic            per_oe_i,
    output logic [PW-1:0]   per_o,
    output logic            per_oe_o,
    output logic            arr_clk_o,
    output logic            mc_clk_o,
    output logic            tmr_clk_o,
    output logic            clkin_buf_en_o,
    output logic            pd_o,
    output logic            sleep_o,
    output logic            ovf_o
);
    logic                 cnt_en_q, slp_sel_q;
    logic [NUM_GATES-1:0] gate_off_q;
    logic [REGW-1:0]      tc_q;
    logic                 wake_any, hit, lp;
    logic [NUM_GATES-1:0] gclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_en_q   <= 1'b0;
            slp_sel_q  <= 1'b0;
            gate_off_q <= '0;
            tc_q       <= '0;
        end else if (wr_en_i) begin
            if (wr_sel_i) begin
                tc_q <= wr_data_i;
            end else begin
                cnt_en_q   <= wr_data_i[BIT_CNT_EN];
                slp_sel_q  <= wr_data_i[BIT_SLP_SEL];
                gate_off_q <= {wr_data_i[BIT_TMR_OFF], wr_data_i[BIT_MC_OFF],
                               wr_data_i[BIT_ARR_OFF]};
            end
        end
    end

    assign wake_any = bus_act_i | wr_en_i | wake_i;

    for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
        pd_clk_gate u_gate (
            .clk    (clk),
            .en_i   (!gate_off_q[g]),
            .gclk_o (gclk[g])
        );
    end
    assign arr_clk_o = gclk[0];
    assign mc_clk_o  = gclk[1];
    assign tmr_clk_o = gclk[2];

    pd_idle_cnt #(.TCW(REGW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (cnt_en_q),
        .clr_i (wake_any),
        .lp_i  (lp),
        .tc_i  (tc_q),
        .hit_o (hit)
    );

    pd_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_i       (hit),
        .wake_i      (wake_any),
        .sleep_sel_i (slp_sel_q),
        .lp_o        (lp),
        .pd_o        (pd_o),
        .sleep_o     (sleep_o),
        .ovf_o       (ovf_o)
    );

    pd_pin_ctrl #(.IOW(IOW), .DW(DW), .AW(AW), .PW(PW)) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .lp_i      (lp),
        .io_i      (io_i),
        .io_oe_i   (io_oe_i),
        .io_o      (io_o),
        .io_oe_o   (io_oe_o),
        .data_i    (data_i),
        .data_oe_i (data_oe_i),
        .data_o    (data_o),
        .data_oe_o (data_oe_o),
        .addr_i    (addr_i),
        .addr_o    (addr_o),
        .per_i     (per_i),
        .per_oe_i  (per_oe_i),
        .per_o     (per_o),
        .per_oe_o  (per_oe_o)
    );

    assign logic_o        = logic_i;
    assign clkin_buf_en_o = !((&gate_off_q) && ovf_o);

    AST_BUF_OFF_COND: assert property (@(posedge clk) disable iff (!rst_n)
        !clkin_buf_en_o |-> ((pd_o || sleep_o) && (&gate_off_q))); // R9
    AST_LP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pd_o, sleep_o})); // R5
endmodule

// File: tb/pwrdn_ctrl_bench.sv
module pwrdn_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TC = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 0, wr_sel = 0, bus_act = 0, wake = 0;
    logic [7:0] wr_data = '0;
    logic [3:0] logic_i = '0, logic_o;
    logic [7:0] io_i = '0, io_oe_i = '0, io_o, io_oe_o;
    logic [7:0] data_i = '0, data_o;
    logic data_oe_i = 0, data_oe_o;
    logic [15:0] addr_i = '0, addr_o;
    logic [3:0] per_i = '0, per_o;
    logic per_oe_i = 0, per_oe_o;
    logic arr_clk, mc_clk, tmr_clk, buf_en, pd, slp, ovf;

    int n_checks = 0, n_errors = 0;
    int n_arr = 0, n_mc = 0, n_tmr = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwrdn_ctrl u_pwrdn_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
        .wr_data_i(wr_data), .bus_act_i(bus_act), .wake_i(wake),
        .logic_i(logic_i), .logic_o(logic_o), .io_i(io_i), .io_oe_i(io_oe_i),
        .io_o(io_o), .io_oe_o(io_oe_o), .data_i(data_i), .data_oe_i(data_oe_i),
        .data_o(data_o), .data_oe_o(data_oe_o), .addr_i(addr_i), .addr_o(addr_o),
        .per_i(per_i), .per_oe_i(per_oe_i), .per_o(per_o), .per_oe_o(per_oe_o),
        .arr_clk_o(arr_clk), .mc_clk_o(mc_clk), .tmr_clk_o(tmr_clk),
        .clkin_buf_en_o(buf_en), .pd_o(pd), .sleep_o(slp), .ovf_o(ovf)
    );

    always @(posedge arr_clk) n_arr++;
    always @(posedge mc_clk)  n_mc++;
    always @(posedge tmr_clk) n_tmr++;

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write(bit sel, logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic clocks(string req, int ea, int em, int et);
        int a0, m0, t0;
        @(negedge clk);
        a0 = n_arr; m0 = n_mc; t0 = n_tmr;
        repeat (8) @(negedge clk);
        check({req, " arr_clk"}, n_arr - a0, ea);
        check({req, " mc_clk"},  n_mc - m0,  em);
        check({req, " tmr_clk"}, n_tmr - t0, et);
    endtask

    // Entry is due on the TC+1-th edge after the last activity edge
    task automatic expect_entry(string req, bit sleep_mode);
        repeat (TC) @(negedge clk);
        check({req, " not yet low power"}, int'(pd | slp), 0);
        @(negedge clk);
        check({req, " pd_o"}, int'(pd), int'(!sleep_mode));
        check({req, " sleep_o"}, int'(slp), int'(sleep_mode));
        check({req, " ovf_o"}, int'(ovf), 1);
    endtask

    task automatic do_wake(string req);
        wake = 1;
        @(negedge clk);
        wake = 0;
        check({req, " exit pd"}, int'(pd | slp), 0);
        check({req, " exit ovf"}, int'(ovf), 0);
        check({req, " exit buf"}, int'(buf_en), 1);
    endtask

    task automatic t_reset;
        check("R1 pd", int'(pd), 0);
        check("R1 sleep", int'(slp), 0);
        check("R1 ovf", int'(ovf), 0);
        check("R1 buf", int'(buf_en), 1);
        clocks("R1", 8, 8, 8);
        repeat (20) @(negedge clk);
        check("R1 counter off, no entry", int'(pd | slp), 0);
    endtask

    task automatic t_gates;
        write(1, TC[7:0]);
        write(0, 8'h20); clocks("R2", 0, 8, 8);
        write(0, 8'h40); clocks("R3", 8, 0, 8);
        write(0, 8'h80); clocks("R4", 8, 8, 0);
        write(0, 8'h00); clocks("R2 R3 R4 cleared", 8, 8, 8);
    endtask

    task automatic t_entry_wake;
        write(0, 8'h01);
        expect_entry("R5 power-down", 0);
        check("R9 buf stays on", int'(buf_en), 1);
        do_wake("R8");
        expect_entry("R7 full restart", 0);
        do_wake("R8 second");
    endtask

    task automatic t_activity;
        repeat (2) @(negedge clk);
        bus_act = 1;
        @(negedge clk);
        bus_act = 0;
        expect_entry("R6 activity restart", 0);
        bus_act = 1;
        @(negedge clk);
        bus_act = 0;
        check("R8 bus exit", int'(pd), 0);
        write(0, 8'h00);
        repeat (10) @(negedge clk);
        check("R5 disabled counter", int'(pd | slp), 0);
    endtask

    task automatic t_pins;
        io_i = 8'hA5; io_oe_i = 8'h0F; data_oe_i = 1; per_oe_i = 1;
        addr_i = 16'h1234; logic_i = 4'h3;
        write(0, 8'h01);
        check("R10 io run", int'(io_o), 'hA5);
        check("R11 addr run", int'(addr_o), 'h1234);
        check("R11 data_oe run", int'(data_oe_o), 1);
        repeat (TC + 1) @(negedge clk);
        io_i = 8'h5A; io_oe_i = 8'hF0; logic_i = 4'hC;
        @(negedge clk);
        check("R10 io held", int'(io_o), 'hA5);
        check("R10 io_oe held", int'(io_oe_o), 'h0F);
        check("R11 data_oe off", int'(data_oe_o), 0);
        check("R11 per_oe off", int'(per_oe_o), 0);
        check("R11 addr zero", int'(addr_o), 0);
        check("R12 logic follows", int'(logic_o), 'hC);
        do_wake("R8 pins");
        check("R10 io live again", int'(io_o), 'h5A);
    endtask

    task automatic t_buffer;
        write(0, 8'h63);
        expect_entry("R5 sleep", 1);
        check("R9 two gates only", int'(buf_en), 1);
        do_wake("R8 sleep");
        write(0, 8'hE1);
        expect_entry("R9 all gates", 0);
        check("R9 buf off", int'(buf_en), 0);
        do_wake("R9 buf back");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_gates();
        t_entry_wake();
        t_activity();
        t_pins();
        t_buffer();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule